// File: doc/BRIEF.md
# Single-clock FIFO with per-access handshakes and threshold flags

This block is a first-in first-out buffer whose write side and read side run on one shared clock. The producer presents a word together with a write request. The consumer raises a read request and takes the oldest stored word from a registered data output. Each request is answered one clock later by a registered pulse:

- On the write side, the pulse says the word was stored or that it was refused because the buffer was full.
- On the read side, the pulse says a word was delivered or that nothing was taken because the buffer was empty.

A refused access never disturbs the stored words or the pointers.

Depth is a power of two set by an address-width parameter. A single threshold parameter serves two flags:

- The almost-empty flag, raised while the buffer holds that many words or fewer.
- The almost-full flag, raised while that many free slots or fewer remain.

All four level flags (full, empty, almost-full, almost-empty) are registered. They change on the same edge as the occupancy they describe. Reset is active low and is sampled on the clock edge.

Top module: `lockstep_fifo`

## Requirements
- R1: While reset is low at a clock edge, the block returns to: empty=1, full=0, almost_empty=1, almost_full=1 only when THRESH equals the depth, all four handshake outputs 0, and rd_data=0.
- R2: Words leave in the order they were accepted. rd_data takes the next word on the edge that accepts a read and otherwise holds its value.
- R3: wr_ack is 1 for exactly the cycle after a write request that was accepted, meaning wr_en=1 while full=0.
- R4: overflow is 1 for the cycle after a write request made while full=1. The word is dropped and the stored contents are unchanged.
- R5: rd_valid is 1 for exactly the cycle after a read request that was accepted, meaning rd_en=1 while empty=0.
- R6: underflow is 1 for the cycle after a read request made while empty=1. No word is taken and rd_data holds.
- R7: full is 1 exactly when occupancy equals 2^ADDR_W. empty is 1 exactly when occupancy is 0.
- R8: almost_empty is 1 exactly when occupancy is less than or equal to THRESH.
- R9: almost_full is 1 exactly when occupancy is at least 2^ADDR_W minus THRESH.
- R10: A read and a write in the same cycle, when the buffer is neither empty nor full, both complete and leave the occupancy unchanged.
- R11: A read and a write in the same cycle on a full buffer perform the read and refuse the write (overflow). On an empty buffer they perform the write and refuse the read (underflow).
- R12: Pulling reset low in the middle of traffic discards every stored word. After release the block behaves as freshly reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Active-low reset, sampled on the clock edge |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | Buffer holds 2^ADDR_W words |
| wr_ack | output | 1 | Previous write request was stored |
| overflow | output | 1 | Previous write request was refused |
| almost_full | output | 1 | At most THRESH free slots |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered oldest word |
| empty | output | 1 | Buffer holds no words |
| rd_valid | output | 1 | Previous read request delivered a word |
| underflow | output | 1 | Previous read request found the buffer empty |
| almost_empty | output | 1 | At most THRESH words stored |

## Verification
The bench builds the block with DATA_W=8, ADDR_W=3 and THRESH=2. The eight-entry depth lets a short burst of writes reach full, so the refused-write and read-while-full paths are exercised many times within a few hundred cycles. With a threshold of 2, the almost-empty flag changes between two and three stored words and the almost-full flag between five and six. Both flag edges therefore fall inside ordinary random traffic instead of only at the extremes.

// File: rtl/lockstep_fifo_pkg.sv
package lockstep_fifo_pkg;

  // Per-access answers, all registered one clock after the request.
  typedef struct packed {
    logic wr_ack;
    logic overflow;
    logic rd_valid;
    logic underflow;
  } access_resp_t;

  localparam access_resp_t RESP_IDLE = '{default: 1'b0};

endpackage

// File: rtl/lockstep_fifo_gate.sv
module lockstep_fifo_gate
  import lockstep_fifo_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic         full,
  input  logic         empty,
  output logic         wr_go,
  output logic         rd_go,
  output access_resp_t resp
);

  access_resp_t resp_d;
  access_resp_t resp_q;

  always_comb begin
    wr_go = wr_en & ~full;
    rd_go = rd_en & ~empty;
  end

  always_comb begin
    resp_d           = RESP_IDLE;
    resp_d.wr_ack    = wr_go;
    resp_d.overflow  = wr_en & full;
    resp_d.rd_valid  = rd_go;
    resp_d.underflow = rd_en & empty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) resp_q <= RESP_IDLE;
    else        resp_q <= resp_d;
  end

  assign resp = resp_q;

  // R4
  overflow_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_q.overflow |-> $past(full));
  // R3
  ack_not_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_q.wr_ack |-> !$past(full));
  // R6
  underflow_after_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_q.underflow |-> $past(empty));
  // R5
  valid_underflow_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_q.rd_valid && resp_q.underflow));

endmodule

// File: rtl/lockstep_fifo_ptrs.sv
module lockstep_fifo_ptrs #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              rd_go,
  output logic [ADDR_W-1:0] wr_idx,
  output logic [ADDR_W-1:0] rd_idx,
  output logic [ADDR_W:0]   level_q,
  output logic [ADDR_W:0]   level_d
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] wr_idx_q, wr_idx_d;
  logic [ADDR_W-1:0] rd_idx_q, rd_idx_d;

  always_comb begin
    wr_idx_d = wr_idx_q;
    rd_idx_d = rd_idx_q;
    level_d  = level_q;
    if (wr_go) wr_idx_d = wr_idx_q + 1'b1;
    if (rd_go) rd_idx_d = rd_idx_q + 1'b1;
    case ({wr_go, rd_go})
      2'b10:   level_d = level_q + 1'b1;
      2'b01:   level_d = level_q - 1'b1;
      default: level_d = level_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      level_q  <= '0;
    end else begin
      wr_idx_q <= wr_idx_d;
      rd_idx_q <= rd_idx_d;
      level_q  <= level_d;
    end
  end

  assign wr_idx = wr_idx_q;
  assign rd_idx = rd_idx_q;

  // R7
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= DEPTH_C);
  // R10
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go == rd_go) |=> $stable(level_q));

endmodule

// File: rtl/lockstep_fifo_store.sv
module lockstep_fifo_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] dout_q, dout_d;

  always_ff @(posedge clk) begin
    if (wr_go) cells[wr_idx] <= wr_data;
  end

  always_comb begin
    dout_d = dout_q;
    if (rd_go) dout_d = cells[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign rd_data = dout_q;

  // R2
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(dout_q));

endmodule

// File: rtl/lockstep_fifo_status.sv
module lockstep_fifo_status #(
  parameter int ADDR_W = 4,
  parameter int THRESH = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ADDR_W:0] level_d,
  input  logic [ADDR_W:0] level_q,
  output logic            full,
  output logic            empty,
  output logic            almost_full,
  output logic            almost_empty
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] AE_LVL  = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] AF_LVL  = CNT_W'(DEPTH - THRESH);
  localparam logic AF_RST = (THRESH >= DEPTH);

  logic full_q, empty_q, af_q, ae_q;
  logic full_d, empty_d, af_d, ae_d;

  always_comb begin
    full_d  = (level_d == DEPTH_C);
    empty_d = (level_d == '0);
    af_d    = (level_d >= AF_LVL);
    ae_d    = (level_d <= AE_LVL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      af_q    <= AF_RST;
      ae_q    <= 1'b1;
    end else begin
      full_q  <= full_d;
      empty_q <= empty_d;
      af_q    <= af_d;
      ae_q    <= ae_d;
    end
  end

  assign full         = full_q;
  assign empty        = empty_q;
  assign almost_full  = af_q;
  assign almost_empty = ae_q;

  // R7
  full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_q == (level_q == DEPTH_C));
  // R7
  empty_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_q == (level_q == '0));
  // R8
  ae_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ae_q == (level_q <= AE_LVL));
  // R9
  af_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    af_q == (level_q >= AF_LVL));

endmodule

// File: rtl/lockstep_fifo.sv
module lockstep_fifo
  import lockstep_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int THRESH = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  output logic              wr_ack,
  output logic              overflow,
  output logic              almost_full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              rd_valid,
  output logic              underflow,
  output logic              almost_empty
);

  logic              wr_go, rd_go;
  logic [ADDR_W-1:0] wr_idx, rd_idx;
  logic [ADDR_W:0]   level_q, level_d;
  access_resp_t      resp;

  lockstep_fifo_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .full  (full),
    .empty (empty),
    .wr_go (wr_go),
    .rd_go (rd_go),
    .resp  (resp)
  );

  lockstep_fifo_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_go   (wr_go),
    .rd_go   (rd_go),
    .wr_idx  (wr_idx),
    .rd_idx  (rd_idx),
    .level_q (level_q),
    .level_d (level_d)
  );

  lockstep_fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_go   (wr_go),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_go   (rd_go),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  lockstep_fifo_status #(.ADDR_W(ADDR_W), .THRESH(THRESH)) u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .level_d      (level_d),
    .level_q      (level_q),
    .full         (full),
    .empty        (empty),
    .almost_full  (almost_full),
    .almost_empty (almost_empty)
  );

  assign wr_ack    = resp.wr_ack;
  assign overflow  = resp.overflow;
  assign rd_valid  = resp.rd_valid;
  assign underflow = resp.underflow;

  // R11
  full_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en) |=> (overflow && !wr_ack));
  // R11
  empty_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en) |=> (underflow && !rd_valid));

endmodule

// File: tb/lockstep_fifo_tb.sv
module lockstep_fifo_tb;

  localparam int DW    = 8;
  localparam int AW    = 3;
  localparam int TH    = 2;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [DW-1:0] wr_data;
  logic          full, wr_ack, overflow, almost_full;
  logic [DW-1:0] rd_data;
  logic          empty, rd_valid, underflow, almost_empty;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  string phase = "";

  // reference model state
  logic [DW-1:0] q[$];
  logic [DW-1:0] e_dout;
  logic e_ack, e_ovf, e_val, e_udf;

  always #10 clk = ~clk;

  lockstep_fifo #(.DATA_W(DW), .ADDR_W(AW), .THRESH(TH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .full(full), .wr_ack(wr_ack),
    .overflow(overflow), .almost_full(almost_full),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .rd_valid(rd_valid),
    .underflow(underflow), .almost_empty(almost_empty)
  );

  task automatic chk(input string req, input string sig, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s %s: actual %0d expected %0d at %0t", req, phase, sig, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int n;
    n = q.size();
    chk("R2", "rd_data",      int'(rd_data),      int'(e_dout));
    chk("R3", "wr_ack",       int'(wr_ack),       int'(e_ack));
    chk("R4", "overflow",     int'(overflow),     int'(e_ovf));
    chk("R5", "rd_valid",     int'(rd_valid),     int'(e_val));
    chk("R6", "underflow",    int'(underflow),    int'(e_udf));
    chk("R7", "full",         int'(full),         int'(n == DEPTH));
    chk("R7", "empty",        int'(empty),        int'(n == 0));
    chk("R8", "almost_empty", int'(almost_empty), int'(n <= TH));
    chk("R9", "almost_full",  int'(almost_full),  int'(n >= DEPTH - TH));
  endtask

  // One clock: drive at negedge, update model at posedge, compare at next negedge.
  task automatic step(input logic rst, input logic w, input logic [DW-1:0] d, input logic r);
    bit mf, me, dw, dr;
    rst_n = rst; wr_en = w; wr_data = d; rd_en = r;
    @(posedge clk);
    if (!rst) begin
      q.delete();
      e_dout = '0; e_ack = 0; e_ovf = 0; e_val = 0; e_udf = 0;
    end else begin
      mf = (q.size() == DEPTH);
      me = (q.size() == 0);
      dw = w && !mf;
      dr = r && !me;
      if (dr) e_dout = q.pop_front();
      if (dw) q.push_back(d);
      e_ack = dw; e_ovf = w && mf; e_val = dr; e_udf = r && me;
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    @(negedge clk);
    phase = "reset";
    step(0, 0, 8'h00, 0);
    step(0, 1, 8'h11, 1);
    // R1: reset values, THRESH < depth so almost_full is low
    chk("R1", "empty",        int'(empty), 1);
    chk("R1", "full",         int'(full), 0);
    chk("R1", "almost_empty", int'(almost_empty), 1);
    chk("R1", "almost_full",  int'(almost_full), 0);
    chk("R1", "handshakes",   int'({wr_ack, overflow, rd_valid, underflow}), 0);
    chk("R1", "rd_data",      int'(rd_data), 0);

    // R6: read while empty
    phase = "R6 empty read";
    step(1, 0, 8'h00, 1);
    chk("R6", "underflow", int'(underflow), 1);

    // R11: read and write together on empty buffer
    phase = "R11 empty rw";
    step(1, 1, 8'hA0, 1);
    chk("R11", "wr_ack/underflow", int'({wr_ack, underflow}), 3);

    // fill to full
    phase = "R7 fill";
    for (int i = 1; i < DEPTH; i++) step(1, 1, 8'(8'hA0 + i), 0);
    chk("R7", "full after fill", int'(full), 1);

    // R4: write while full
    phase = "R4 overflow";
    step(1, 1, 8'hEE, 0);
    chk("R4", "overflow", int'(overflow), 1);

    // R11: read and write together on full buffer
    phase = "R11 full rw";
    step(1, 1, 8'hEF, 1);
    chk("R11", "overflow/rd_valid", int'({overflow, rd_valid}), 3);
    chk("R11", "rd_data", int'(rd_data), 8'hA0);

    // drain, checking order and that dropped words never appear (R2, R4)
    phase = "R2 drain";
    for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 8'h00, 1);

    // R10: simultaneous traffic at mid occupancy
    phase = "R10 mid rw";
    for (int i = 0; i < 4; i++) step(1, 1, 8'(8'h40 + i), 0);
    for (int i = 0; i < 6; i++) step(1, 1, 8'(8'h50 + i), 1);
    chk("R10", "occupancy via almost flags", int'({almost_empty, almost_full}), 0);

    // random traffic
    phase = "random";
    for (int i = 0; i < 1500; i++)
      step(1, 1'($urandom_range(0, 99) < 55), 8'($urandom), 1'($urandom_range(0, 99) < 45));

    // R12: reset mid-traffic
    phase = "R12 mid reset";
    for (int i = 0; i < 5; i++) step(1, 1, 8'(8'h70 + i), 0);
    step(0, 1, 8'h99, 1);
    chk("R12", "empty", int'(empty), 1);
    chk("R12", "rd_data", int'(rd_data), 0);
    step(1, 0, 8'h00, 1);
    chk("R12", "underflow", int'(underflow), 1);
    step(1, 1, 8'h5A, 0);
    step(1, 0, 8'h00, 1);
    chk("R12", "rd_data", int'(rd_data), 8'h5A);

    phase = "random2";
    for (int i = 0; i < 1500; i++)
      step(1, 1'($urandom_range(0, 99) < 40), 8'($urandom), 1'($urandom_range(0, 99) < 60));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule